// File: doc/BRIEF.md
# Flash command sequencer

This block is the command front end of an on-chip flash array. Software writes 8-bit command codes to one write-only command register. The block decodes these writes into an array operating mode: read, program, program verify, erase, erase verify or auto erase. Some commands take effect on a single write. Others need the same code written twice in a row. Program takes the write that follows its code as the address and data to program. Read mode is the default and stays in force until another command arrives.

Commands count only while reprogramming is enabled. That needs a software select bit at 1 and the external programming-voltage input high. The voltage input is brought through a synchroniser with a parameterised number of stages. The enable is shown on a monitor flag. When the enable drops, the block aborts any operation in progress and returns to read mode.

The array itself is modelled as a handshake. The block pulses a start strobe, holds busy high and waits for a done pulse. The command register has no read path, so software can never read back a command code.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, mode_o is 0 (read), busy_o is 0 and op_start_o is 0.
- R2: mon_o is 1 only when sel_i is 1 and vpp_i, delayed by SYNC_STAGES clocks (default 2), is 1. While mon_o is 0, writes have no effect and mode_o stays 0.
- R3: With mon_o at 1 and no operation in progress, a single write selects a mode, visible from the cycle after the write: 0x00 gives read (mode 0), 0xC0 gives program verify (mode 2) and 0xA0 gives erase verify (mode 4). The mode then holds over any number of idle cycles. mode_o is never above 5.
- R4: Two consecutive writes of 0x20 select erase (mode 3). Two consecutive writes of 0x30 select auto erase (mode 5). In either case op_start_o pulses for one cycle after the second write and busy_o goes to 1. op_start_o never rises without a write in the cycle before.
- R5: Two consecutive writes of 0xFF return the mode to read (0) and start no array operation.
- R6: If the second write of a 0x20, 0x30 or 0xFF pair carries a different code, the mode becomes read (0), op_start_o stays 0 and busy_o stays 0. Until that second write, the mode keeps its previous value.
- R7: A write of 0x40 selects program (mode 1). The next write, whatever its code, is taken as the operation: prog_addr_o and prog_data_o take that write's address and data, op_start_o pulses and busy_o stays 1 until done_i is seen.
- R8: While busy_o is 1, command writes are ignored and mode_o is unchanged.
- R9: A single write of a code outside the set 00, 40, C0, A0, 20, 30, FF leaves the mode unchanged.
- R10: If mon_o goes to 0 while an operation is in progress, busy_o and mode_o return to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Software reprogramming-mode select bit |
| vpp_i | input | 1 | Programming voltage present (asynchronous) |
| wr_i | input | 1 | Write strobe to the command register |
| wr_data_i | input | 8 | Command code or program data |
| wr_addr_i | input | ADDR_W | Array address carried with the write |
| done_i | input | 1 | Array reports the operation finished |
| mon_o | output | 1 | Reprogramming mode valid |
| mode_o | output | 3 | Array mode: 0 read, 1 program, 2 program verify, 3 erase, 4 erase verify, 5 auto erase |
| busy_o | output | 1 | Array operation in progress |
| op_start_o | output | 1 | One-cycle start strobe to the array |
| prog_addr_o | output | ADDR_W | Captured program address |
| prog_data_o | output | 8 | Captured program data |

## Verification
The bench sends a mismatched second write of a pair and then checks that the mode falls to read with no start strobe. A design that committed on the first write, or that kept the pending code, would start a spurious erase. It also writes 0xFF as the program data to check that the write after 0x40 is taken as data and not as half of a reset pair. It writes while busy, so a design that dropped the busy guard would show a changed mode. Finally it removes the programming voltage in the middle of an erase, where a design lacking the abort would stay busy and stuck in erase mode.

// File: rtl/flash_cmd_pkg.sv
// Shared codes and types of the flash command sequencer.
// Assumes 8-bit command writes; the mode encoding is visible at the top port.
package flash_cmd_pkg;
    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CODE_READ  = 8'h00;
    localparam logic [CMD_W-1:0] CODE_PROG  = 8'h40;
    localparam logic [CMD_W-1:0] CODE_PVFY  = 8'hC0;
    localparam logic [CMD_W-1:0] CODE_EVFY  = 8'hA0;
    localparam logic [CMD_W-1:0] CODE_ERASE = 8'h20;
    localparam logic [CMD_W-1:0] CODE_AUTO  = 8'h30;
    localparam logic [CMD_W-1:0] CODE_RESET = 8'hFF;

    typedef enum logic [2:0] {
        MODE_READ  = 3'd0,
        MODE_PROG  = 3'd1,
        MODE_PVFY  = 3'd2,
        MODE_ERASE = 3'd3,
        MODE_EVFY  = 3'd4,
        MODE_AUTO  = 3'd5
    } fmode_e;

    typedef enum logic [2:0] {
        CK_READ, CK_PROG, CK_PVFY, CK_EVFY,
        CK_ERASE1, CK_AUTO1, CK_RESET1, CK_NONE
    } ckind_e;

    typedef enum logic [1:0] {
        PEND_NONE, PEND_ERASE, PEND_AUTO, PEND_RESET
    } pend_e;

    // Code the second write of a pending pair must repeat.
    function automatic logic [CMD_W-1:0] pend_code(input pend_e p);
        case (p)
            PEND_ERASE: pend_code = CODE_ERASE;
            PEND_AUTO:  pend_code = CODE_AUTO;
            default:    pend_code = CODE_RESET;
        endcase
    endfunction
endpackage

// File: rtl/flash_cmd_decode.sv
// Classifies one command byte into a command kind.
// Purely combinational; bytes outside the command set map to CK_NONE.
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [CMD_W-1:0] code_i,
    output ckind_e           kind_o
);
    // Map the byte onto its command kind.
    always_comb begin
        case (code_i)
            CODE_READ:  kind_o = CK_READ;
            CODE_PROG:  kind_o = CK_PROG;
            CODE_PVFY:  kind_o = CK_PVFY;
            CODE_EVFY:  kind_o = CK_EVFY;
            CODE_ERASE: kind_o = CK_ERASE1;
            CODE_AUTO:  kind_o = CK_AUTO1;
            CODE_RESET: kind_o = CK_RESET1;
            default:    kind_o = CK_NONE;
        endcase
    end
endmodule

// File: rtl/flash_mode_gate.sv
// Forms the reprogramming-mode valid flag from the select bit and the
// programming-voltage input. The voltage is asynchronous to clk and is
// passed through SYNC_STAGES flops (0 means it is already synchronous).
module flash_mode_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic vpp_i,
    output logic mon_o
);
    logic vpp_s;

    if (SYNC_STAGES == 0) begin : g_direct
        assign vpp_s = vpp_i;
    end else begin : g_sync
        logic [SYNC_STAGES-1:0] sh;
        // Shift the voltage level through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh <= '0;
            end else begin
                sh[0] <= vpp_i;
                for (int i = 1; i < SYNC_STAGES; i++) begin
                    sh[i] <= sh[i-1];
                end
            end
        end
        assign vpp_s = sh[SYNC_STAGES-1];
    end

    assign mon_o = sel_i & vpp_s;
endmodule

// File: rtl/flash_cmd_fsm.sv
// Command sequencing state: current mode, half-received pair, program
// arming and the busy handshake with the array. Writes are acted on only
// while mon_i is high and no operation is in progress; a low mon_i
// returns everything to read mode on the next clock.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_i,
    input  logic              wr_i,
    input  logic [CMD_W-1:0]  code_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  ckind_e            kind_i,
    input  logic              done_i,
    output fmode_e            mode_o,
    output logic              busy_o,
    output logic              start_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [CMD_W-1:0]  prog_data_o
);
    fmode_e            mode_q;
    pend_e             pend_q;
    logic              arm_q;
    logic              busy_q;
    logic              start_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  data_q;
    logic              pair_ok;

    assign pair_ok = (code_i == pend_code(pend_q));

    // Advance the command state on each accepted write or array event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_READ;
            pend_q  <= PEND_NONE;
            arm_q   <= 1'b0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            start_q <= 1'b0;
            if (!mon_i) begin
                mode_q <= MODE_READ;
                pend_q <= PEND_NONE;
                arm_q  <= 1'b0;
                busy_q <= 1'b0;
            end else if (busy_q) begin
                if (done_i) begin
                    busy_q <= 1'b0;
                end
            end else if (wr_i) begin
                if (arm_q) begin
                    arm_q   <= 1'b0;
                    addr_q  <= addr_i;
                    data_q  <= code_i;
                    start_q <= 1'b1;
                    busy_q  <= 1'b1;
                end else if (pend_q != PEND_NONE) begin
                    pend_q <= PEND_NONE;
                    if (!pair_ok) begin
                        mode_q <= MODE_READ;
                    end else begin
                        case (pend_q)
                            PEND_ERASE: begin
                                mode_q  <= MODE_ERASE;
                                start_q <= 1'b1;
                                busy_q  <= 1'b1;
                            end
                            PEND_AUTO: begin
                                mode_q  <= MODE_AUTO;
                                start_q <= 1'b1;
                                busy_q  <= 1'b1;
                            end
                            default: mode_q <= MODE_READ;
                        endcase
                    end
                end else begin
                    case (kind_i)
                        CK_READ:   mode_q <= MODE_READ;
                        CK_PROG: begin
                            mode_q <= MODE_PROG;
                            arm_q  <= 1'b1;
                        end
                        CK_PVFY:   mode_q <= MODE_PVFY;
                        CK_EVFY:   mode_q <= MODE_EVFY;
                        CK_ERASE1: pend_q <= PEND_ERASE;
                        CK_AUTO1:  pend_q <= PEND_AUTO;
                        CK_RESET1: pend_q <= PEND_RESET;
                        default:   ;
                    endcase
                end
            end
        end
    end

    assign mode_o      = mode_q;
    assign busy_o      = busy_q;
    assign start_o     = start_q;
    assign prog_addr_o = addr_q;
    assign prog_data_o = data_q;
endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command sequencer: enable gate, byte decoder and
// sequencing state. The command register is write-only: no read path
// exists. Assumes the array answers each start with one done pulse.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              vpp_i,
    input  logic              wr_i,
    input  logic [CMD_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              done_i,
    output logic              mon_o,
    output logic [2:0]        mode_o,
    output logic              busy_o,
    output logic              op_start_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [CMD_W-1:0]  prog_data_o
);
    logic   mon;
    ckind_e kind;
    fmode_e mode;

    flash_mode_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (sel_i),
        .vpp_i (vpp_i),
        .mon_o (mon)
    );

    flash_cmd_decode u_dec (
        .code_i (wr_data_i),
        .kind_o (kind)
    );

    flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mon_i       (mon),
        .wr_i        (wr_i),
        .code_i      (wr_data_i),
        .addr_i      (wr_addr_i),
        .kind_i      (kind),
        .done_i      (done_i),
        .mode_o      (mode),
        .busy_o      (busy_o),
        .start_o     (op_start_o),
        .prog_addr_o (prog_addr_o),
        .prog_data_o (prog_data_o)
    );

    assign mon_o  = mon;
    assign mode_o = mode;
endmodule

// File: rtl/flash_cmd_chk.sv
// Protocol checker for the flash command sequencer, bound to the top.
module flash_cmd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_i,
    input logic       done_i,
    input logic       mon_o,
    input logic [2:0] mode_o,
    input logic       busy_o,
    input logic       op_start_o
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 3'd0) && !busy_o && !op_start_o); // R1

    AST_MON_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_o |=> (mode_o == 3'd0)); // R2

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd5); // R3

    AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_start_o) |-> $past(wr_i)); // R4

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && mon_o && !done_i |=> busy_o); // R7

    AST_BUSY_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && mon_o |=> $stable(mode_o)); // R8

    AST_ABORT_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !mon_o |=> !busy_o && (mode_o == 3'd0)); // R10
endmodule

bind flash_cmd_seq flash_cmd_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_i),
    .done_i     (done_i),
    .mon_o      (mon_o),
    .mode_o     (mode_o),
    .busy_o     (busy_o),
    .op_start_o (op_start_o)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/100ps
// Bench for the flash command sequencer: a behavioural reference model
// compared on every falling edge, plus directed checks per requirement.
module flash_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0;
    logic        vpp_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [7:0]  wr_data_i = 8'h00;
    logic [15:0] wr_addr_i = 16'h0000;
    logic        done_i = 1'b0;
    logic        mon_o;
    logic [2:0]  mode_o;
    logic        busy_o;
    logic        op_start_o;
    logic [15:0] prog_addr_o;
    logic [7:0]  prog_data_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    flash_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .vpp_i(vpp_i),
        .wr_i(wr_i), .wr_data_i(wr_data_i), .wr_addr_i(wr_addr_i),
        .done_i(done_i), .mon_o(mon_o), .mode_o(mode_o), .busy_o(busy_o),
        .op_start_o(op_start_o), .prog_addr_o(prog_addr_o),
        .prog_data_o(prog_data_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model: state kept as plain integers, voltage delay as a queue.
    int m_mode = 0, m_busy = 0, m_start = 0, m_arm = 0, m_pend = -1;
    int m_addr = 0, m_data = 0;
    bit vq[$] = '{1'b0, 1'b0};

    function automatic bit known_code(input int c);
        return c == 8'h00 || c == 8'h40 || c == 8'hC0 || c == 8'hA0 ||
               c == 8'h20 || c == 8'h30 || c == 8'hFF;
    endfunction

    always @(posedge clk) begin
        bit mon;
        mon = sel_i & vq[0];
        if (!rst_n) begin
            m_mode = 0; m_busy = 0; m_start = 0; m_arm = 0; m_pend = -1;
            m_addr = 0; m_data = 0;
            vq = '{1'b0, 1'b0};
        end else begin
            m_start = 0;
            if (!mon) begin
                m_mode = 0; m_busy = 0; m_arm = 0; m_pend = -1;
            end else if (m_busy != 0) begin
                if (done_i) m_busy = 0;
            end else if (wr_i) begin
                if (m_arm != 0) begin
                    m_arm = 0; m_addr = wr_addr_i; m_data = wr_data_i;
                    m_start = 1; m_busy = 1;
                end else if (m_pend >= 0) begin
                    if (wr_data_i != m_pend) m_mode = 0;
                    else if (m_pend == 8'h20) begin m_mode = 3; m_start = 1; m_busy = 1; end
                    else if (m_pend == 8'h30) begin m_mode = 5; m_start = 1; m_busy = 1; end
                    else m_mode = 0;
                    m_pend = -1;
                end else if (known_code(wr_data_i)) begin
                    case (wr_data_i)
                        8'h00: m_mode = 0;
                        8'h40: begin m_mode = 1; m_arm = 1; end
                        8'hC0: m_mode = 2;
                        8'hA0: m_mode = 4;
                        default: m_pend = wr_data_i;
                    endcase
                end
            end
            void'(vq.pop_front());
            vq.push_back(vpp_i);
        end
    end

    // Compare the design with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cur_req, mon_o, sel_i & vq[0]);
            check(cur_req, mode_o, m_mode);
            check(cur_req, busy_o, m_busy);
            check(cur_req, op_start_o, m_start);
            if (m_start != 0) begin
                check(cur_req, prog_addr_o, m_addr);
                check(cur_req, prog_data_o, m_data);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write(input logic [7:0] d, input logic [15:0] a);
        wr_i = 1'b1; wr_data_i = d; wr_addr_i = a;
        tick(1);
        wr_i = 1'b0;
    endtask

    task automatic finish_op();
        done_i = 1'b1;
        tick(1);
        done_i = 1'b0;
        tick(1);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        cur_req = "R1";
        check("R1", mode_o, 0);
        check("R1", busy_o, 0);
        check("R1", op_start_o, 0);

        // Select bit set but no voltage: writes do nothing.
        cur_req = "R2";
        sel_i = 1'b1;
        write(8'h40, 16'h0);
        tick(1);
        check("R2", mon_o, 0);
        check("R2", mode_o, 0);
        vpp_i = 1'b1;
        tick(1);
        check("R2", mon_o, 0);
        tick(2);
        check("R2", mon_o, 1);

        cur_req = "R3";
        write(8'hC0, 16'h0);
        check("R3", mode_o, 2);
        tick(20);
        check("R3", mode_o, 2);
        write(8'hA0, 16'h0);
        check("R3", mode_o, 4);
        write(8'h00, 16'h0);
        check("R3", mode_o, 0);

        cur_req = "R9";
        write(8'hC0, 16'h0);
        write(8'h55, 16'h0);
        tick(1);
        check("R9", mode_o, 2);
        write(8'h01, 16'h0);
        check("R9", mode_o, 2);

        cur_req = "R4";
        write(8'h20, 16'h0);
        check("R4", mode_o, 2);
        check("R4", op_start_o, 0);
        write(8'h20, 16'h0);
        check("R4", mode_o, 3);
        check("R4", op_start_o, 1);
        check("R4", busy_o, 1);
        tick(1);
        check("R4", op_start_o, 0);

        cur_req = "R8";
        write(8'h00, 16'h0);
        write(8'hC0, 16'h0);
        tick(1);
        check("R8", mode_o, 3);
        check("R8", busy_o, 1);
        finish_op();
        check("R8", busy_o, 0);
        check("R8", mode_o, 3);

        cur_req = "R4";
        write(8'h30, 16'h0);
        write(8'h30, 16'h0);
        check("R4", mode_o, 5);
        check("R4", op_start_o, 1);
        finish_op();

        cur_req = "R5";
        write(8'hFF, 16'h0);
        check("R5", mode_o, 5);
        write(8'hFF, 16'h0);
        check("R5", mode_o, 0);
        check("R5", op_start_o, 0);
        check("R5", busy_o, 0);

        cur_req = "R6";
        write(8'hC0, 16'h0);
        write(8'h20, 16'h0);
        write(8'h30, 16'h0);
        check("R6", mode_o, 0);
        check("R6", op_start_o, 0);
        check("R6", busy_o, 0);
        write(8'hA0, 16'h0);
        write(8'h30, 16'h0);
        write(8'h20, 16'h0);
        check("R6", mode_o, 0);
        check("R6", busy_o, 0);

        cur_req = "R7";
        write(8'h40, 16'h0);
        check("R7", mode_o, 1);
        check("R7", busy_o, 0);
        write(8'hFF, 16'h1234);
        check("R7", op_start_o, 1);
        check("R7", prog_addr_o, 16'h1234);
        check("R7", prog_data_o, 8'hFF);
        tick(6);
        check("R7", busy_o, 1);
        finish_op();
        check("R7", busy_o, 0);
        check("R7", mode_o, 1);
        write(8'h40, 16'h0);
        write(8'h5A, 16'h00C3);
        check("R7", prog_data_o, 8'h5A);
        finish_op();

        cur_req = "R10";
        write(8'h20, 16'h0);
        write(8'h20, 16'h0);
        check("R10", busy_o, 1);
        vpp_i = 1'b0;
        tick(4);
        check("R10", mon_o, 0);
        check("R10", busy_o, 0);
        check("R10", mode_o, 0);
        vpp_i = 1'b1;
        tick(4);
        write(8'h30, 16'h0);
        write(8'h30, 16'h0);
        check("R10", busy_o, 1);
        sel_i = 1'b0;
        tick(2);
        check("R10", busy_o, 0);
        check("R10", mode_o, 0);
        write(8'hC0, 16'h0);
        tick(1);
        check("R2", mode_o, 0);
        tick(2);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule